// File: doc/BRIEF.md
# SMBus Target Transaction Decoder

This block turns a stream of byte-level bus events into SMBus transaction requests for a target application. Each cycle carries at most one event: start of a write phase, start of a read phase, one byte written by the host, a request for one byte to return, a host NACK, or the end of the transfer. The block sorts these into a quick command (with its direction bit), a single sent byte, a command write with a run of data bytes, a receive-byte fetch, and indexed reads keyed by (command, index).

Written bytes are held in a local buffer because the kind of a write is only known later. The block classifies the write at the stop, or at a repeated start into a read phase, from the number of bytes collected. Read bytes are fetched from the application through a request port that is answered in the same cycle. The reply goes back to the bus side one cycle later. Protocol violations drive the decoder into an error state that only the end of a transfer clears.

Top module: `smb_target_fsm`

## Requirements
- R1: After reset the state code is 0 (idle). No delivery pulse, read request or reply is active.
- R2: State codes are 0 idle, 1 collecting write, 2 single receive, 3 indexed read, 4 read finished, 5 error. A write start in idle moves to 1. A read start in idle moves to 2. A write start in any state other than idle moves to 5.
- R3: In state 1 each written byte is stored at the next buffer position, up to BUF_DEPTH (34) bytes. Further bytes are dropped, so the data count reported for a command write never exceeds BUF_DEPTH-1.
- R4: The end of a transfer in state 1 causes one delivery pulse in the following cycle, chosen by the byte count. With 0 bytes it is a quick command with direction 0. With 1 byte it is a send byte carrying that byte. With 2 or more it is a command write: the first byte is the command, the count is the byte count minus one, and app_buf_sel = k reads data byte k (buffer position k+1).
- R5: A read start in state 1 depends on the byte count. With 0 bytes the state goes to 5. With 1 byte that byte becomes the read command and nothing is delivered. With 2 or more bytes the pending command write is delivered first and its first byte becomes the read command. In the last two cases the read index is cleared and the state becomes 3.
- R6: A read request in state 3 raises app_rd_vld in the same cycle, with app_rd_indexed=1, the latched command and the current index. The index then increments. rsp_vld and rsp_byte carry the application's byte in the next cycle.
- R7: A read request in state 2 raises app_rd_vld with app_rd_indexed=0. The byte is returned in the next cycle and the state becomes 4. The end of a transfer in state 2 with no read issues a quick command with direction 1.
- R8: A NACK in state 3 moves to state 4. A NACK in state 4 leaves the state unchanged. A NACK in any other state moves to state 5.
- R9: Every end of transfer returns the state to 0 and empties the buffer, so the next write starts counting from zero.
- R10: A read request in any state other than 2 or 3 returns rsp_byte 0x00 with rsp_err set in the next cycle and moves to state 5.
- R11: A written byte outside state 1 is not stored. Event codes 6 and 7 are ignored. Event codes: 0 write start, 1 read start, 2 write byte, 3 read request, 4 NACK, 5 end of transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | An event is present this cycle |
| ev_kind | input | 3 | Event code (see R11) |
| ev_data | input | 8 | Byte for a write-byte event |
| st_code | output | 3 | Decoder state code (see R2) |
| app_quick_vld | output | 1 | Quick command pulse |
| app_quick_rd | output | 1 | Direction bit of the quick command |
| app_send_vld | output | 1 | Send-byte pulse |
| app_send_byte | output | 8 | Byte of the send-byte transaction |
| app_wr_vld | output | 1 | Command-write pulse |
| app_wr_cmd | output | 8 | Command byte of the write |
| app_wr_cnt | output | 6 | Number of data bytes after the command |
| app_buf_sel | input | 6 | Data byte index to read from the buffer |
| app_buf_data | output | 8 | Selected data byte |
| app_rd_vld | output | 1 | Read fetch request, same cycle as the event |
| app_rd_indexed | output | 1 | 1 = indexed read, 0 = receive byte |
| app_rd_cmd | output | 8 | Command for an indexed read |
| app_rd_idx | output | 8 | Index within an indexed read |
| app_rd_data | input | 8 | Application byte answering the fetch |
| rsp_vld | output | 1 | Reply byte valid |
| rsp_byte | output | 8 | Reply byte to the bus side |
| rsp_err | output | 1 | Reply to a read request in a wrong state |

## Verification
A table walk drives event orderings through every state and checks the state code after each event. It covers legal write and read sequences, NACKs in each phase, starts while busy, stray bytes and unused codes. Directed cases finish writes of 0, 1, 4 and 40 bytes, which tells the three write kinds and buffer saturation apart. Repeated starts after 0, 1 and 2 bytes separate the error, command-latch and flush-then-read paths. Successive indexed reads with distinct application bytes show that the index steps and that the command was taken from the right byte.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WDATA = 3'd1,
    ST_RECV  = 3'd2,
    ST_RDATA = 3'd3,
    ST_DONE  = 3'd4,
    ST_ERR   = 3'd5
  } st_e;

  localparam logic [2:0] EV_START_WR = 3'd0;
  localparam logic [2:0] EV_START_RD = 3'd1;
  localparam logic [2:0] EV_WR_BYTE  = 3'd2;
  localparam logic [2:0] EV_RD_REQ   = 3'd3;
  localparam logic [2:0] EV_NACK     = 3'd4;
  localparam logic [2:0] EV_FINISH   = 3'd5;

  typedef enum logic [1:0] {
    WK_QUICK = 2'd0,
    WK_SEND  = 2'd1,
    WK_CMD   = 2'd2
  } wk_e;

  // Decoded event strobes, at most one set per cycle.
  typedef struct packed {
    logic start_wr;
    logic start_rd;
    logic wr_byte;
    logic rd_req;
    logic nack;
    logic finish;
  } evs_t;

  // Actions the control FSM asks of the buffer and the port.
  typedef struct packed {
    logic push;
    logic clear;
    logic flush;
    logic quick_rd;
    logic latch_cmd;
    logic idx_clr;
    logic idx_inc;
    logic rd_hit;
    logic rd_indexed;
    logic rd_bad;
  } act_t;

  // Kind of a write, chosen by how many bytes were collected.
  function automatic wk_e write_kind(input int unsigned nbytes);
    if (nbytes == 0)      return WK_QUICK;
    else if (nbytes == 1) return WK_SEND;
    else                  return WK_CMD;
  endfunction

  // Data bytes following the command byte.
  function automatic int unsigned data_count(input int unsigned nbytes);
    return (nbytes == 0) ? 0 : nbytes - 1;
  endfunction

endpackage

// File: rtl/smb_tgt_wbuf.sv
module smb_tgt_wbuf
  import smb_tgt_pkg::*;
#(
  parameter int unsigned DEPTH = 34,
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             clear,
  input  logic [7:0]       din,
  input  logic [LEN_W-1:0] sel,
  output logic [LEN_W-1:0] len,
  output logic [7:0]       head,
  output logic [7:0]       sel_data
);

  logic [7:0]       ent [DEPTH];
  logic [LEN_W-1:0] len_q;
  logic [DEPTH-1:0] we;
  logic [LEN_W:0]   rd_addr;

  // One write enable per entry: the next free slot takes the byte.
  for (genvar g = 0; g < DEPTH; g++) begin : g_we
    assign we[g] = push && (len_q == LEN_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) ent[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (we[k]) ent[k] <= din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 len_q <= '0;
    else if (clear)                             len_q <= '0;
    else if (push && (len_q < LEN_W'(DEPTH)))   len_q <= len_q + 1'b1;
  end

  // Data byte k sits one position after the command byte.
  assign rd_addr = {1'b0, sel} + 1'b1;

  always_comb begin
    sel_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (rd_addr == (LEN_W + 1)'(k)) sel_data = ent[k];
    end
  end

  assign len  = len_q;
  assign head = ent[0];

endmodule

// File: rtl/smb_tgt_ctl.sv
module smb_tgt_ctl
  import smb_tgt_pkg::*;
#(
  parameter int unsigned LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  evs_t             evs,
  input  logic [LEN_W-1:0] buf_len,
  output st_e              state,
  output act_t             act
);

  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    act  = '0;
    if (evs.start_wr) begin
      st_d = (st_q == ST_IDLE) ? ST_WDATA : ST_ERR;
    end else if (evs.start_rd) begin
      if (st_q == ST_IDLE) begin
        st_d = ST_RECV;
      end else if (st_q == ST_WDATA) begin
        if (buf_len == '0) begin
          st_d = ST_ERR;
        end else begin
          act.latch_cmd = 1'b1;
          act.flush     = (buf_len > LEN_W'(1));
          act.clear     = 1'b1;
          act.idx_clr   = 1'b1;
          st_d          = ST_RDATA;
        end
      end else begin
        st_d = ST_ERR;
      end
    end else if (evs.wr_byte) begin
      act.push = (st_q == ST_WDATA);
    end else if (evs.rd_req) begin
      if (st_q == ST_RECV) begin
        act.rd_hit = 1'b1;
        st_d       = ST_DONE;
      end else if (st_q == ST_RDATA) begin
        act.rd_hit     = 1'b1;
        act.rd_indexed = 1'b1;
        act.idx_inc    = 1'b1;
      end else begin
        act.rd_bad = 1'b1;
        st_d       = ST_ERR;
      end
    end else if (evs.nack) begin
      if (st_q == ST_RDATA)     st_d = ST_DONE;
      else if (st_q != ST_DONE) st_d = ST_ERR;
    end else if (evs.finish) begin
      act.flush    = (st_q == ST_WDATA);
      act.quick_rd = (st_q == ST_RECV);
      act.clear    = 1'b1;
      st_d         = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/smb_tgt_port.sv
module smb_tgt_port
  import smb_tgt_pkg::*;
#(
  parameter int unsigned LEN_W = 6,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  act_t             act,
  input  logic [LEN_W-1:0] buf_len,
  input  logic [7:0]       buf_head,
  input  logic [7:0]       app_rd_data,
  output logic             app_quick_vld,
  output logic             app_quick_rd,
  output logic             app_send_vld,
  output logic [7:0]       app_send_byte,
  output logic             app_wr_vld,
  output logic [7:0]       app_wr_cmd,
  output logic [LEN_W-1:0] app_wr_cnt,
  output logic             app_rd_vld,
  output logic             app_rd_indexed,
  output logic [7:0]       app_rd_cmd,
  output logic [IDX_W-1:0] app_rd_idx,
  output logic             rsp_vld,
  output logic [7:0]       rsp_byte,
  output logic             rsp_err
);

  wk_e              kind;
  logic [7:0]       cmd_q;
  logic [IDX_W-1:0] idx_q;

  assign kind = write_kind(int'(buf_len));

  // Transaction delivery pulses, one cycle after the deciding event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      app_quick_vld <= 1'b0;
      app_quick_rd  <= 1'b0;
      app_send_vld  <= 1'b0;
      app_send_byte <= '0;
      app_wr_vld    <= 1'b0;
      app_wr_cmd    <= '0;
      app_wr_cnt    <= '0;
    end else begin
      app_quick_vld <= 1'b0;
      app_send_vld  <= 1'b0;
      app_wr_vld    <= 1'b0;
      if (act.flush) begin
        unique case (kind)
          WK_QUICK: begin
            app_quick_vld <= 1'b1;
            app_quick_rd  <= 1'b0;
          end
          WK_SEND: begin
            app_send_vld  <= 1'b1;
            app_send_byte <= buf_head;
          end
          default: begin
            app_wr_vld <= 1'b1;
            app_wr_cmd <= buf_head;
            app_wr_cnt <= LEN_W'(data_count(int'(buf_len)));
          end
        endcase
      end else if (act.quick_rd) begin
        app_quick_vld <= 1'b1;
        app_quick_rd  <= 1'b1;
      end
    end
  end

  // Read command and running index.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      idx_q <= '0;
    end else begin
      if (act.latch_cmd) cmd_q <= buf_head;
      if (act.idx_clr)       idx_q <= '0;
      else if (act.idx_inc)  idx_q <= idx_q + 1'b1;
    end
  end

  assign app_rd_vld     = act.rd_hit;
  assign app_rd_indexed = act.rd_indexed;
  assign app_rd_cmd     = cmd_q;
  assign app_rd_idx     = idx_q;

  // Reply path to the bus side.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld  <= 1'b0;
      rsp_byte <= '0;
      rsp_err  <= 1'b0;
    end else begin
      rsp_vld  <= act.rd_hit | act.rd_bad;
      rsp_byte <= act.rd_hit ? app_rd_data : 8'h00;
      rsp_err  <= act.rd_bad;
    end
  end

endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
  import smb_tgt_pkg::*;
#(
  parameter int unsigned BUF_DEPTH = 34,
  parameter int unsigned IDX_W     = 8,
  localparam int unsigned LEN_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [2:0]       ev_kind,
  input  logic [7:0]       ev_data,
  output logic [2:0]       st_code,
  output logic             app_quick_vld,
  output logic             app_quick_rd,
  output logic             app_send_vld,
  output logic [7:0]       app_send_byte,
  output logic             app_wr_vld,
  output logic [7:0]       app_wr_cmd,
  output logic [LEN_W-1:0] app_wr_cnt,
  input  logic [LEN_W-1:0] app_buf_sel,
  output logic [7:0]       app_buf_data,
  output logic             app_rd_vld,
  output logic             app_rd_indexed,
  output logic [7:0]       app_rd_cmd,
  output logic [IDX_W-1:0] app_rd_idx,
  input  logic [7:0]       app_rd_data,
  output logic             rsp_vld,
  output logic [7:0]       rsp_byte,
  output logic             rsp_err
);

  // Named event strobes, also watched by the checker.
  logic ev_start_wr, ev_start_rd, ev_wr_byte, ev_rd_req, ev_nack, ev_finish;
  assign ev_start_wr = ev_valid && (ev_kind == EV_START_WR);
  assign ev_start_rd = ev_valid && (ev_kind == EV_START_RD);
  assign ev_wr_byte  = ev_valid && (ev_kind == EV_WR_BYTE);
  assign ev_rd_req   = ev_valid && (ev_kind == EV_RD_REQ);
  assign ev_nack     = ev_valid && (ev_kind == EV_NACK);
  assign ev_finish   = ev_valid && (ev_kind == EV_FINISH);

  evs_t             evs;
  act_t             act;
  st_e              state;
  logic [LEN_W-1:0] buf_len;
  logic [7:0]       buf_head;

  assign evs = '{start_wr: ev_start_wr, start_rd: ev_start_rd,
                 wr_byte:  ev_wr_byte,  rd_req:   ev_rd_req,
                 nack:     ev_nack,     finish:   ev_finish};

  smb_tgt_ctl #(.LEN_W(LEN_W)) ctl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .evs     (evs),
    .buf_len (buf_len),
    .state   (state),
    .act     (act)
  );

  smb_tgt_wbuf #(.DEPTH(BUF_DEPTH)) wbuf_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (act.push),
    .clear    (act.clear),
    .din      (ev_data),
    .sel      (app_buf_sel),
    .len      (buf_len),
    .head     (buf_head),
    .sel_data (app_buf_data)
  );

  smb_tgt_port #(.LEN_W(LEN_W), .IDX_W(IDX_W)) port_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .act            (act),
    .buf_len        (buf_len),
    .buf_head       (buf_head),
    .app_rd_data    (app_rd_data),
    .app_quick_vld  (app_quick_vld),
    .app_quick_rd   (app_quick_rd),
    .app_send_vld   (app_send_vld),
    .app_send_byte  (app_send_byte),
    .app_wr_vld     (app_wr_vld),
    .app_wr_cmd     (app_wr_cmd),
    .app_wr_cnt     (app_wr_cnt),
    .app_rd_vld     (app_rd_vld),
    .app_rd_indexed (app_rd_indexed),
    .app_rd_cmd     (app_rd_cmd),
    .app_rd_idx     (app_rd_idx),
    .rsp_vld        (rsp_vld),
    .rsp_byte       (rsp_byte),
    .rsp_err        (rsp_err)
  );

  assign st_code = state;

endmodule

// File: rtl/smb_target_fsm_chk.sv
module smb_target_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_start_wr,
  input logic       ev_rd_req,
  input logic       ev_nack,
  input logic       ev_finish,
  input logic [2:0] st_code,
  input logic       app_quick_vld,
  input logic       app_send_vld,
  input logic       app_wr_vld,
  input logic       rsp_vld,
  input logic       rsp_err,
  input logic [7:0] rsp_byte
);

  p_single_delivery_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({app_quick_vld, app_send_vld, app_wr_vld}) <= 1);

  p_finish_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> (st_code == 3'd0));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start_wr && st_code != 3'd0) |=> (st_code == 3'd5));

  p_nack_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_nack && st_code == 3'd4) |=> (st_code == 3'd4));

  p_reply_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_req |=> rsp_vld);

  p_recv_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_req && st_code == 3'd2) |=> (st_code == 3'd4));

  p_bad_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_vld && rsp_byte == 8'h00));

endmodule

bind smb_target_fsm smb_target_fsm_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .ev_start_wr   (ev_start_wr),
  .ev_rd_req     (ev_rd_req),
  .ev_nack       (ev_nack),
  .ev_finish     (ev_finish),
  .st_code       (st_code),
  .app_quick_vld (app_quick_vld),
  .app_send_vld  (app_send_vld),
  .app_wr_vld    (app_wr_vld),
  .rsp_vld       (rsp_vld),
  .rsp_err       (rsp_err),
  .rsp_byte      (rsp_byte)
);

// File: tb/smb_target_fsm_tb.sv
module smb_target_fsm_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] K_SW = 3'd0, K_SR = 3'd1, K_WB = 3'd2,
                         K_RQ = 3'd3, K_NK = 3'd4, K_FN = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0;
  logic [2:0] ev_kind = '0;
  logic [7:0] ev_data = '0;
  logic [5:0] app_buf_sel = '0;
  logic [7:0] app_rd_data;
  logic [2:0] st_code;
  logic       app_quick_vld, app_quick_rd, app_send_vld, app_wr_vld;
  logic [7:0] app_send_byte, app_wr_cmd, app_buf_data, app_rd_cmd, app_rd_idx;
  logic [5:0] app_wr_cnt;
  logic       app_rd_vld, app_rd_indexed, rsp_vld, rsp_err;
  logic [7:0] rsp_byte;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Application model: receive-byte gives a constant, indexed reads a mix.
  function automatic logic [7:0] app_model(input logic [7:0] c, input logic [7:0] i);
    return (c ^ {i[3:0], i[7:4]}) + 8'd1;
  endfunction
  assign app_rd_data = app_rd_indexed ? app_model(app_rd_cmd, app_rd_idx) : 8'hA5;

  smb_target_fsm dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_data(ev_data), .st_code(st_code),
    .app_quick_vld(app_quick_vld), .app_quick_rd(app_quick_rd),
    .app_send_vld(app_send_vld), .app_send_byte(app_send_byte),
    .app_wr_vld(app_wr_vld), .app_wr_cmd(app_wr_cmd), .app_wr_cnt(app_wr_cnt),
    .app_buf_sel(app_buf_sel), .app_buf_data(app_buf_data),
    .app_rd_vld(app_rd_vld), .app_rd_indexed(app_rd_indexed),
    .app_rd_cmd(app_rd_cmd), .app_rd_idx(app_rd_idx), .app_rd_data(app_rd_data),
    .rsp_vld(rsp_vld), .rsp_byte(rsp_byte), .rsp_err(rsp_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Same-cycle fetch request captured while the event is applied.
  logic       c_vld, c_idxd;
  logic [7:0] c_cmd, c_idx;

  // Apply one event at a falling edge; return at the next falling edge,
  // where the registered results of that event are visible.
  task automatic ev(input logic [2:0] k, input logic [7:0] d);
    ev_valid = 1'b1; ev_kind = k; ev_data = d;
    #1;
    c_vld = app_rd_vld; c_idxd = app_rd_indexed; c_cmd = app_rd_cmd; c_idx = app_rd_idx;
    @(negedge clk);
    ev_valid = 1'b0; ev_kind = '0; ev_data = '0;
  endtask

  task automatic pulses(input string tag, input logic q, input logic s, input logic w);
    chk(tag, {29'd0, app_quick_vld, app_send_vld, app_wr_vld}, {29'd0, q, s, w});
  endtask

  // {event kind, data, state code expected after the event}
  localparam logic [13:0] VEC [27] = '{
    {K_SW, 8'h00, 3'd1}, {K_WB, 8'h10, 3'd1}, {K_WB, 8'h20, 3'd1}, {K_FN, 8'h00, 3'd0},
    {K_SR, 8'h00, 3'd2}, {K_RQ, 8'h00, 3'd4}, {K_NK, 8'h00, 3'd4}, {K_FN, 8'h00, 3'd0},
    {K_SW, 8'h00, 3'd1}, {K_WB, 8'h05, 3'd1}, {K_SR, 8'h00, 3'd3}, {K_RQ, 8'h00, 3'd3},
    {K_RQ, 8'h00, 3'd3}, {K_NK, 8'h00, 3'd4}, {K_FN, 8'h00, 3'd0}, {K_NK, 8'h00, 3'd5},
    {K_FN, 8'h00, 3'd0}, {K_SW, 8'h00, 3'd1}, {K_SW, 8'h00, 3'd5}, {K_FN, 8'h00, 3'd0},
    {K_WB, 8'h99, 3'd0}, {3'd7, 8'h00, 3'd0}, {K_SR, 8'h00, 3'd2}, {K_SW, 8'h00, 3'd5},
    {K_FN, 8'h00, 3'd0}, {K_RQ, 8'h00, 3'd5}, {K_FN, 8'h00, 3'd0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 state", {29'd0, st_code}, 32'd0);
    pulses("R1 pulses", 0, 0, 0);
    chk("R1 rsp", {31'd0, rsp_vld}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state after release", {29'd0, st_code}, 32'd0);

    // Table walk over state transitions (R2, R7, R8, R10, R11).
    for (int i = 0; i < $size(VEC); i++) begin
      ev(VEC[i][13:11], VEC[i][10:3]);
      chk($sformatf("R2/R8 table step %0d", i), {29'd0, st_code}, {29'd0, VEC[i][2:0]});
    end

    // R4: zero bytes -> quick write
    ev(K_SW, 0); ev(K_FN, 0);
    pulses("R4 quick write pulses", 1, 0, 0);
    chk("R4 quick dir", {31'd0, app_quick_rd}, 32'd0);

    // R11: stray byte in idle not stored -> next empty write still quick
    ev(K_WB, 8'h99); ev(7, 8'h42); ev(K_SW, 0); ev(K_FN, 0);
    pulses("R11 stray byte ignored", 1, 0, 0);

    // R4: one byte -> send byte
    ev(K_SW, 0); ev(K_WB, 8'h3C); ev(K_FN, 0);
    pulses("R4 send pulses", 0, 1, 0);
    chk("R4 send byte", {24'd0, app_send_byte}, 32'h3C);

    // R4: command plus three data bytes
    ev(K_SW, 0); ev(K_WB, 8'h40); ev(K_WB, 8'h01); ev(K_WB, 8'h02); ev(K_WB, 8'h03);
    ev(K_FN, 0);
    pulses("R4 cmd write pulses", 0, 0, 1);
    chk("R4 cmd", {24'd0, app_wr_cmd}, 32'h40);
    chk("R4 cnt", {26'd0, app_wr_cnt}, 32'd3);
    for (int k = 0; k < 3; k++) begin
      app_buf_sel = 6'(k); #1;
      chk("R4 data byte", {24'd0, app_buf_data}, 32'(k + 1));
    end

    // R3: 40 bytes, buffer saturates at 34
    ev(K_SW, 0);
    for (int k = 0; k < 40; k++) ev(K_WB, 8'h80 + 8'(k));
    ev(K_FN, 0);
    chk("R3 cnt saturates", {26'd0, app_wr_cnt}, 32'd33);
    chk("R3 cmd", {24'd0, app_wr_cmd}, 32'h80);
    app_buf_sel = 6'd32; #1;
    chk("R3 last kept byte", {24'd0, app_buf_data}, 32'hA1);

    // R9: length restarted after finish
    ev(K_SW, 0); ev(K_WB, 8'h11); ev(K_WB, 8'h22); ev(K_FN, 0);
    chk("R9 cnt restart", {26'd0, app_wr_cnt}, 32'd1);
    chk("R9 cmd", {24'd0, app_wr_cmd}, 32'h11);
    app_buf_sel = 6'd0; #1;
    chk("R9 data", {24'd0, app_buf_data}, 32'h22);

    // R5: one byte then repeated start -> latch command, no delivery
    ev(K_SW, 0); ev(K_WB, 8'h07); ev(K_SR, 0);
    pulses("R5 no delivery", 0, 0, 0);
    chk("R5 state", {29'd0, st_code}, 32'd3);
    // R6: indexed reads
    for (int k = 0; k < 3; k++) begin
      ev(K_RQ, 0);
      chk("R6 fetch vld/indexed", {30'd0, c_vld, c_idxd}, 32'd3);
      chk("R6 fetch cmd", {24'd0, c_cmd}, 32'h07);
      chk("R6 fetch idx", {24'd0, c_idx}, 32'(k));
      chk("R6 reply", {23'd0, rsp_vld, rsp_byte}, {23'd0, 1'b1, app_model(8'h07, 8'(k))});
    end
    ev(K_NK, 0); ev(K_FN, 0);
    pulses("R5 no quick at end", 0, 0, 0);

    // R5: two bytes then repeated start -> flush write, then read
    ev(K_SW, 0); ev(K_WB, 8'h09); ev(K_WB, 8'hAB); ev(K_SR, 0);
    pulses("R5 flush pulses", 0, 0, 1);
    chk("R5 flush cmd", {24'd0, app_wr_cmd}, 32'h09);
    chk("R5 flush cnt", {26'd0, app_wr_cnt}, 32'd1);
    app_buf_sel = 6'd0; #1;
    chk("R5 flush data", {24'd0, app_buf_data}, 32'hAB);
    ev(K_RQ, 0);
    chk("R5 read cmd and idx", {16'd0, c_cmd, c_idx}, 32'h0900);
    ev(K_FN, 0);

    // R5: zero bytes then repeated start -> error
    ev(K_SW, 0); ev(K_SR, 0);
    chk("R5 empty repeated start", {29'd0, st_code}, 32'd5);
    ev(K_FN, 0);

    // R7: receive byte, then quick read
    ev(K_SR, 0); ev(K_RQ, 0);
    chk("R7 fetch plain", {30'd0, c_vld, c_idxd}, 32'd2);
    chk("R7 reply", {23'd0, rsp_vld, rsp_byte}, 32'h1A5);
    chk("R7 state", {29'd0, st_code}, 32'd4);
    ev(K_FN, 0);
    pulses("R7 no quick after byte", 0, 0, 0);
    ev(K_SR, 0); ev(K_FN, 0);
    pulses("R7 quick read pulse", 1, 0, 0);
    chk("R7 quick dir", {31'd0, app_quick_rd}, 32'd1);

    // R10: read request in idle
    ev(K_RQ, 0);
    chk("R10 reply", {22'd0, rsp_vld, rsp_err, rsp_byte}, 32'h300);
    chk("R10 fetch not raised", {31'd0, c_vld}, 32'd0);
    chk("R10 state", {29'd0, st_code}, 32'd5);
    ev(K_FN, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule